// File: doc/BRIEF.md
# Edge-Triggered GPIO Port with Interrupt Masking

This block is a 16-pin general-purpose I/O port behind a small word-addressed register interface. The interface has an address, a write strobe, a read strobe and 32-bit data. Software controls each pin through a set of per-pin bit registers:

- an output latch;
- a direction register;
- a polarity register;
- an interrupt mask;
- a sticky interrupt status register;
- an ownership register, which claims pins for the processor side.

Software can also read the current pin levels through a read-only sample register.

Each pin's input passes through a two-flop synchroniser. The synchronised level feeds an edge detector. The polarity bit chooses whether that pin records its rising edge or its falling edge, but never both. A recorded edge sets the pin's status bit whether or not the pin is masked. The single interrupt line to the parent controller is a registered OR of the status bits whose mask bit is clear.

The register word offsets are:

| Offset | Register |
|--------|----------|
| 0x00 | output latch |
| 0x04 | direction |
| 0x08 | polarity |
| 0x0C | mask |
| 0x10 | status |
| 0x14 | ownership |
| 0x18 | input sample |
| 0x1C | unmapped |

Address bits [1:0] are ignored. Register bit i belongs to pin i, and bits 31..16 always read as zero.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the registers hold these values:
  - output latch 0x0000;
  - direction 0xFFFF (all pins inputs, `pin_oe` = 0);
  - polarity 0x0000;
  - mask 0xFFFF (all pins blocked);
  - status 0x0000;
  - ownership 0x0000.
  In addition, `irq_out` is 0.
- R2: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 makes the pin drive the output latch (`pin_oe` bit 1). `pin_out` equals the output latch from the clock edge that writes it. `pin_oe` changes only on a write to the direction register.
- R3: Reading the input sample register (0x18) returns the pin levels after the two-flop synchroniser.
- R4: With polarity bit 1, a 0-to-1 transition on the synchronised pin sets the pin's status bit. A 1-to-0 transition does not.
- R5: With polarity bit 0, a 1-to-0 transition on the synchronised pin sets the pin's status bit. A 0-to-1 transition does not.
- R6: A status bit is set by its selected edge even when the pin's mask bit is 1.
- R7: `irq_out` equals, one cycle later, the OR over all pins of (status AND NOT mask). A mask bit of 1 blocks the pin and 0 passes it.
- R8: Writing status with a 1 in bit i clears bit i. Bits written with 0 keep their value. A status bit never clears without such a write.
- R9: If a pin's selected edge arrives in the same cycle as a write-1 clear of its status bit, the bit stays set.
- R10: The ownership register (0x14) is readable and drives `own_out` bit for bit.
- R11: The read and write rules are:
  - Read data appears on `rdata` in the cycle after `rd_en`.
  - Unmapped offsets read as zero.
  - Writes to the input sample register or to an unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address of the register word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output latch driven toward the pads |
| pin_oe | output | 16 | Output enable per pin (1 = drive) |
| own_out | output | 16 | Processor-side ownership per pin |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
The assertions check four properties on every cycle:
- the interrupt line tracks the unmasked status from the previous cycle;
- no status bit ever drops except under a write-1 clear;
- the output enables move only after a direction write;
- the reset values of mask, status, interrupt and enables hold.

Only the bench scenarios can show that the correct edge sets each status bit for each polarity, and that the synchroniser delay is as specified. The same applies to the same-cycle edge-and-clear race, the read-back of every register, and the writes that must be ignored.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // Register word index (address bits above the byte offset)
  typedef enum logic [2:0] {
    RG_OUT  = 3'd0,
    RG_DIR  = 3'd1,
    RG_POL  = 3'd2,
    RG_MASK = 3'd3,
    RG_STAT = 3'd4,
    RG_OWN  = 3'd5,
    RG_IN   = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] status_q;
  logic [W-1:0] evt;

  // One edge per pin: polarity 1 = rising, 0 = falling
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt[i] = pol[i] ? (smp[i] & ~prev_q[i]) : (~smp[i] & prev_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= smp;
      // set wins over a same-cycle clear
      status_q <= (status_q & ~clr) | evt;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  in_smp,
  input  logic [W-1:0]  status,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  pol_q,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  own_q,
  output logic [W-1:0]  clr,
  output logic [DW-1:0] rdata
);
  localparam int SW = AW - 2;

  logic [SW-1:0] sel;
  logic [W-1:0]  wv;
  logic [W-1:0]  rd_val;
  logic [DW-1:0] rdata_q;
  logic          unused_bits;

  assign sel         = addr[AW-1:2];
  assign wv          = wdata[W-1:0];
  assign unused_bits = ^{addr[1:0], wdata[DW-1:W]};

  assign clr = (wr_en && sel == SW'(RG_STAT)) ? wv : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '1;
      pol_q  <= '0;
      mask_q <= '1;
      own_q  <= '0;
    end else if (wr_en) begin
      if (sel == SW'(RG_OUT))  out_q  <= wv;
      if (sel == SW'(RG_DIR))  dir_q  <= wv;
      if (sel == SW'(RG_POL))  pol_q  <= wv;
      if (sel == SW'(RG_MASK)) mask_q <= wv;
      if (sel == SW'(RG_OWN))  own_q  <= wv;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel == SW'(RG_OUT))  rd_val = out_q;
    if (sel == SW'(RG_DIR))  rd_val = dir_q;
    if (sel == SW'(RG_POL))  rd_val = pol_q;
    if (sel == SW'(RG_MASK)) rd_val = mask_q;
    if (sel == SW'(RG_STAT)) rd_val = status;
    if (sel == SW'(RG_OWN))  rd_val = own_q;
    if (sel == SW'(RG_IN))   rd_val = in_smp;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= DW'(rd_val);
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int W      = 16,
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  own_out,
  output logic          irq_out
);
  logic [W-1:0] smp_w;
  logic [W-1:0] stat_w;
  logic [W-1:0] out_w, dir_w, pol_w, mask_w, own_w, clr_w;
  logic         irq_q;

  gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(smp_w)
  );

  gpio_edge_status #(.W(W)) u_edge (
    .clk(clk), .rst(rst), .smp(smp_w), .pol(pol_w), .clr(clr_w),
    .status(stat_w)
  );

  gpio_regs #(.W(W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .in_smp(smp_w), .status(stat_w),
    .out_q(out_w), .dir_q(dir_w), .pol_q(pol_w), .mask_q(mask_w),
    .own_q(own_w), .clr(clr_w), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_w & ~mask_w);
  end

  assign pin_out = out_w;
  assign pin_oe  = ~dir_w;
  assign own_out = own_w;
  assign irq_out = irq_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [W-1:0]  status,
  input logic [W-1:0]  mask,
  input logic          irq_out,
  input logic [W-1:0]  pin_oe
);
  localparam int SW = AW - 2;

  logic [W-1:0] clr_req;
  logic         dir_wr;
  logic         rst_d;

  assign clr_req = (wr_en && addr[AW-1:2] == SW'(RG_STAT)) ? wdata[W-1:0] : '0;
  assign dir_wr  = wr_en && addr[AW-1:2] == SW'(RG_DIR);

  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_d) begin
      reset_state_chk: assert (mask == '1 && status == '0 && !irq_out && pin_oe == '0);
    end
  end

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(|(status & ~mask))));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status & $past(status & ~clr_req)) == $past(status & ~clr_req)));

  // R2
  oe_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dir_wr)) |-> $stable(pin_oe));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .status(stat_w), .mask(mask_w), .irq_out(irq_out), .pin_oe(pin_oe)
);

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_POL = 5'h08,
                         A_MASK = 5'h0C, A_STAT = 5'h10, A_OWN = 5'h14,
                         A_IN = 5'h18, A_NONE = 5'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, own_out;
  logic        irq_out;
  int          nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .own_out(own_out), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [15:0] bit_m;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 irq", 32'(irq_out), 32'h0);
    rd(A_OUT, v);  chk("R1 out", v, 32'h0);
    rd(A_DIR, v);  chk("R1 dir", v, 32'hFFFF);
    rd(A_POL, v);  chk("R1 pol", v, 32'h0);
    rd(A_MASK, v); chk("R1 mask", v, 32'hFFFF);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_OWN, v);  chk("R1 own", v, 32'h0);

    // R2 direction and output latch
    wr(A_DIR, 32'h0000_00F0);
    chk("R2 oe", 32'(pin_oe), 32'h0000_FF0F);
    wr(A_OUT, 32'hFFFF_A5C3);
    chk("R2 pin_out", 32'(pin_out), 32'h0000_A5C3);
    rd(A_OUT, v); chk("R2 out readback", v, 32'h0000_A5C3);
    wr(A_DIR, 32'h0000_FFFF);
    chk("R2 oe all input", 32'(pin_oe), 32'h0);

    // R10 ownership
    wr(A_OWN, 32'h0000_1234);
    chk("R10 own_out", 32'(own_out), 32'h1234);
    rd(A_OWN, v); chk("R10 own readback", v, 32'h1234);

    // R3 synchronised input sample
    @(negedge clk) pin_in = 16'h5A3C;
    settle();
    rd(A_IN, v); chk("R3 input", v, 32'h5A3C);
    @(negedge clk) pin_in = 16'hC3A5;
    settle();
    rd(A_IN, v); chk("R3 input", v, 32'hC3A5);
    @(negedge clk) pin_in = 16'h0000;
    settle();
    wr(A_STAT, 32'hFFFF);

    // R4 R5 R6 R7 sweep over every pin and both polarities
    for (int p = 0; p < 2; p++) begin
      wr(A_POL, (p == 1) ? 32'hFFFF : 32'h0);
      for (int i = 0; i < 16; i++) begin
        bit_m = 16'(1) << i;
        wr(A_MASK, (i % 2 == 0) ? 32'(~bit_m) : 32'hFFFF);
        wr(A_STAT, 32'hFFFF);
        @(negedge clk) pin_in = pin_in | bit_m;
        settle();
        rd(A_STAT, v);
        chk((p == 1) ? "R4 rise sets" : "R5 rise ignored", v, (p == 1) ? 32'(bit_m) : 32'h0);
        chk("R6 R7 irq after rise", 32'(irq_out), 32'((p == 1) && (i % 2 == 0)));
        wr(A_STAT, 32'hFFFF);
        @(negedge clk) pin_in = pin_in & ~bit_m;
        settle();
        rd(A_STAT, v);
        chk((p == 1) ? "R4 fall ignored" : "R5 fall sets", v, (p == 1) ? 32'h0 : 32'(bit_m));
        chk("R6 R7 irq after fall", 32'(irq_out), 32'((p == 0) && (i % 2 == 0)));
        wr(A_STAT, 32'hFFFF);
      end
    end

    // R8 write-1 clear
    wr(A_POL, 32'hFFFF);
    wr(A_MASK, 32'hFFFF);
    @(negedge clk) pin_in = 16'h0003;
    settle();
    rd(A_STAT, v); chk("R8 both set", v, 32'h3);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R8 one cleared", v, 32'h2);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R8 zero write keeps", v, 32'h2);

    // R9 edge on pin 2 in the same cycle as clearing pins 1 and 2
    @(negedge clk) pin_in = 16'h0007;
    @(negedge clk);
    @(negedge clk);
    addr = A_STAT; wdata = 32'h6; wr_en = 1'b1;
    @(negedge clk) wr_en = 1'b0;
    rd(A_STAT, v); chk("R9 set wins over clear", v, 32'h4);

    // R11 ignored writes and unmapped reads
    wr(A_IN, 32'hFFFF);
    wr(A_NONE, 32'hFFFF);
    rd(A_OUT, v);  chk("R11 out kept", v, 32'hA5C3);
    rd(A_DIR, v);  chk("R11 dir kept", v, 32'hFFFF);
    rd(A_OWN, v);  chk("R11 own kept", v, 32'h1234);
    rd(A_MASK, v); chk("R11 mask kept", v, 32'hFFFF);
    rd(A_NONE, v); chk("R11 unmapped zero", v, 32'h0);
    rd(A_IN, v);   chk("R11 input unchanged", v, 32'h0007);
    chk("R11 pin_out kept", 32'(pin_out), 32'hA5C3);

    summary();
  end
endmodule